// File: doc/BRIEF.md
# Sequencer Trigger Synchronization Unit

This unit ties three LED sequencer channels and one shared external trigger line together. A channel that reaches a trigger instruction hands the 16-bit instruction word to the unit. The unit decodes two masks from that word. The send mask names the channels, and optionally the external line, that should receive a trigger. The wait mask names the sources from which the issuing channel must collect a trigger before it may move on.

Triggers delivered to a channel are held in sticky per-source flags until a wait consumes them. An instruction always occupies its channel for at least 16 timebase ticks, and longer when its wait is not yet satisfied. The timebase is a one-cycle strobe at 32768 Hz.

The external line is active low and open drain. It is modelled as a pull-down enable output and a sampled pin level input. Outgoing external triggers are fixed-length pulses. Incoming ones pass through a synchronizer and a minimum-width qualifier. The unit never counts its own outgoing pulse as an incoming trigger.

Top module: `trig_fabric`

## Requirements
- R1: An instruction word is accepted only when bits 15:13 are 111. The wait mask is read from bits 7, 8, 9 and 12, and the send mask from bits 1, 2, 3 and 6, meaning channel 0, channel 1, channel 2 and external respectively. Bits 4, 5, 10 and 11 have no effect.
- R2: A sent trigger sets a flag at each receiving channel, recording the sender. The flag persists, across any number of ticks, until a wait of that channel consumes it.
- R3: A waiting channel stays busy until every source in its wait mask has a stored flag. `done` then pulses, `busy` falls, and only the flags named in the wait mask are cleared.
- R4: A channel's `done` cannot assert before 16 ticks have been sampled after the issuing cycle. When the wait is already satisfied, `done` is observed right after the 16th tick.
- R5: An external send drives `pin_pull` high from the first tick after issue for exactly three ticks.
- R6: The external input passes through two flops. It is recognized once per low pulse, on the second tick sampled while the synchronized level is low. A pulse covering only one such tick is ignored.
- R7: The pin level is ignored while the unit pulls the line and for the two synchronizer cycles after release, so an external send never satisfies an external wait.
- R8: Within one instruction the send is carried out before the wait. A channel sending to itself and waiting on itself completes after 16 ticks.
- R9: A low `ch_en` bit clears that channel's flags and abandons its pending instruction. Instructions presented while a channel is disabled or busy are ignored.
- R10: After reset, no channel is busy, `done` is low, `pin_pull` is low and no flag is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 32768 Hz timebase strobe |
| ch_en | input | 3 | Per-channel enable; low clears the channel |
| cmd_vld | input | 3 | Per-channel instruction presented this cycle |
| cmd_word | input | 48 | Instruction word, 16 bits per channel, channel 0 lowest |
| pin_in | input | 1 | Sampled trigger pin level (low = asserted) |
| busy | output | 3 | Channel is executing a trigger instruction |
| done | output | 3 | One-cycle completion pulse per channel |
| pin_pull | output | 1 | Pull-down enable for the trigger pin |

## Verification
The bench targets the stickiness of flags and their partial consumption. A design that cleared every flag on completion, or lost a flag sent long before the wait, would release a second wait early or never release it. It also targets self-masking and send-before-wait. A design that listened to its own pulse would finish an external wait with no outside pulse, and a design that evaluated a wait before its own send would hang on a self-trigger. Completion timing, pulse width, single-tick external glitches and the clearing effect of disable are each checked at the exact tick. An off-by-one counter, a missing qualifier or a flag surviving disable therefore shows up as a wrong tick number or a channel left busy.

// File: rtl/trig_fabric.sv
module trig_fabric #(
  parameter int NCH       = 3,
  parameter int IW        = 16,
  parameter int IN_MIN    = 2,
  parameter int OUT_LEN   = 3,
  parameter int CMD_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH-1:0]    cmd_vld,
  input  logic [NCH*IW-1:0] cmd_word,
  input  logic              pin_in,
  output logic [NCH-1:0]    busy,
  output logic [NCH-1:0]    done,
  output logic              pin_pull
);
  localparam int NSRC = NCH + 1;
  localparam int EXT  = NCH;
  localparam int CW   = $clog2(CMD_TICKS + 1);
  localparam int OW   = $clog2(OUT_LEN + 1);
  localparam int LW   = $clog2(IN_MIN + 1);

  logic [NSRC-1:0] flags [NCH];
  logic [NSRC-1:0] wreq  [NCH];
  logic [NSRC-1:0] wsel  [NCH];
  logic [NSRC-1:0] ssel  [NCH];
  logic [NSRC-1:0] hset  [NCH];
  logic [CW-1:0]   cnt   [NCH];
  logic [NCH-1:0]  issue;
  logic            out_go;

  logic          s1, s2, pd1, pd2, self_mask, ext_hit, out_req;
  logic [LW-1:0] lowcnt;
  logic [OW-1:0] out_cnt;

  assign self_mask = pin_pull | pd1 | pd2;
  assign ext_hit   = tick & ~s2 & ~self_mask & (lowcnt == LW'(IN_MIN - 1));
  assign pin_pull  = (out_cnt != '0);

  always_comb begin
    out_go = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      wsel[c]  = {cmd_word[c*IW+12], cmd_word[c*IW+7 +: NCH]};
      ssel[c]  = {cmd_word[c*IW+6],  cmd_word[c*IW+1 +: NCH]};
      issue[c] = cmd_vld[c] & ch_en[c] & ~busy[c] & (cmd_word[c*IW+13 +: 3] == 3'b111);
      done[c]  = busy[c] & (cnt[c] == CW'(CMD_TICKS)) & ((flags[c] & wreq[c]) == wreq[c]);
      out_go   = out_go | (issue[c] & ssel[c][EXT]);
    end
    for (int t = 0; t < NCH; t++) begin
      hset[t][EXT] = ext_hit;
      for (int s = 0; s < NCH; s++) hset[t][s] = issue[s] & ssel[s][t];
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n || !ch_en[c]) begin
        flags[c] <= '0;
        wreq[c]  <= '0;
        cnt[c]   <= '0;
        busy[c]  <= 1'b0;
      end else begin
        flags[c] <= (flags[c] & ~(done[c] ? wreq[c] : '0)) | hset[c];
        if (issue[c]) begin
          busy[c] <= 1'b1;
          cnt[c]  <= '0;
          wreq[c] <= wsel[c];
        end else if (done[c]) begin
          busy[c] <= 1'b0;
        end else if (busy[c] && tick && cnt[c] != CW'(CMD_TICKS)) begin
          cnt[c] <= cnt[c] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; pd1 <= 1'b0; pd2 <= 1'b0;
      lowcnt <= '0; out_cnt <= '0; out_req <= 1'b0;
    end else begin
      s1  <= pin_in;
      s2  <= s1;
      pd1 <= pin_pull;
      pd2 <= pd1;
      if (s2 || self_mask) lowcnt <= '0;
      else if (tick && lowcnt != LW'(IN_MIN)) lowcnt <= lowcnt + 1'b1;
      if (tick && out_cnt != '0) out_cnt <= out_cnt - 1'b1;
      else if (tick && out_req) begin
        out_cnt <= OW'(OUT_LEN);
        out_req <= 1'b0;
      end
      if (out_go) out_req <= 1'b1;
    end
  end

  AST_PULL_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pin_pull) || $fell(pin_pull)) |-> $past(tick)); // R5
  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |=> !ext_hit); // R6

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_NO_SELF_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[g][EXT]) |-> !$past(pin_pull)); // R7
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[g] |=> (flags[g] == '0 && !busy[g])); // R9
    AST_RELEASE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy[g]) && $past(ch_en[g])) |-> $past(done[g])); // R3
  end
endmodule

// File: tb/sim_trig_fabric.sv
module sim_trig_fabric;
  logic clk = 0, rst_n = 0, tick = 0, ext_drv = 0, pp = 0, fin = 0;
  logic [2:0] ch_en = 3'b111, cmd_vld = '0, busy, done;
  logic [47:0] cmd_word = '0;
  logic pin_in, pin_pull;
  logic [2:0] tdiv = '0;
  int tickn = 0, nchk = 0, nerr = 0, rise_t = -1, fall_t = -1;
  int q0[$], q1[$], q2[$];

  always #2.5 clk = ~clk;
  assign pin_in = ~(pin_pull | ext_drv);

  trig_fabric u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .ch_en(ch_en), .cmd_vld(cmd_vld),
    .cmd_word(cmd_word), .pin_in(pin_in), .busy(busy), .done(done), .pin_pull(pin_pull));

  always @(posedge clk) begin
    if (tick) tickn <= tickn + 1;
    tdiv <= tdiv + 1'b1;
    tick <= (tdiv == 3'd7);
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s act=%0d exp=%0d", rq, act, exp); end
  endtask

  task automatic push(input int c, input int t);
    case (c) 0: q0.push_back(t); 1: q1.push_back(t); default: q2.push_back(t); endcase
  endtask

  task automatic pop_chk(input int c);
    int e; bit emp;
    case (c)
      0: begin emp = (q0.size() == 0); if (!emp) e = q0.pop_front(); end
      1: begin emp = (q1.size() == 0); if (!emp) e = q1.pop_front(); end
      default: begin emp = (q2.size() == 0); if (!emp) e = q2.pop_front(); end
    endcase
    if (emp) chk(0, "R3 unexpected done on channel", c, -1);
    else chk(tickn == e, "R4 done tick", tickn, e);
  endtask

  always @(negedge clk) begin
    if (rst_n) for (int c = 0; c < 3; c++) if (done[c]) pop_chk(c);
    if (pin_pull && !pp) rise_t = tickn;
    if (!pin_pull && pp) fall_t = tickn;
    pp = pin_pull;
  end

  task automatic free_slot(); @(negedge clk); while (tick) @(negedge clk); endtask
  task automatic tick_slot(); @(negedge clk); while (!tick) @(negedge clk); endtask
  task automatic drive(input int c, input logic [15:0] w);
    cmd_vld[c] = 1'b1; cmd_word[c*16 +: 16] = w;
    @(negedge clk);
    cmd_vld = '0;
  endtask
  task automatic wait_t(input int n);
    int t0 = tickn;
    while (tickn < t0 + n) @(negedge clk);
  endtask
  task automatic ext_low(input int t, input int k);
    ext_drv = 1'b1;
    while (tickn < t + k) @(negedge clk);
    ext_drv = 1'b0;
  endtask
  task automatic clear_all();
    @(negedge clk); ch_en = '0; @(negedge clk); ch_en = 3'b111;
  endtask

  localparam logic [15:0] OP = 16'hE000;

  initial begin
    int ta, tt;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R10 busy after reset", busy, 0);
    chk(done == 0, "R10 done after reset", done, 0);
    chk(pin_pull == 0, "R10 pull after reset", pin_pull, 0);

    // R1 R4 R2: ch0 sends to ch1, finishes after 16 ticks
    free_slot(); ta = tickn; push(0, ta + 16); drive(0, OP | 16'h0004);
    wait_t(20);
    // R2 R3: ch1 consumes the stored flag
    free_slot(); ta = tickn; push(1, ta + 16); drive(1, OP | 16'h0080);
    wait_t(20);
    // R3: flag consumed, second wait blocks
    free_slot(); drive(1, OP | 16'h0080);
    wait_t(24);
    chk(busy[1] == 1, "R3 wait blocked after consumption", busy[1], 1);
    free_slot(); ta = tickn; push(1, ta); push(0, ta + 16); drive(0, OP | 16'h0004);
    wait_t(20);

    // R3 partial match: ch2 waits on ch0 and ch1
    free_slot(); drive(2, OP | 16'h0180);
    wait_t(20);
    free_slot(); ta = tickn; push(0, ta + 16); drive(0, OP | 16'h0008);
    wait_t(4);
    chk(busy[2] == 1, "R3 partial mask keeps waiting", busy[2], 1);
    free_slot(); tt = tickn; push(2, tt); push(1, tt + 16); drive(1, OP | 16'h0008);
    wait_t(20);

    // R1: unused bits ignored, wrong opcode ignored
    free_slot(); ta = tickn; push(0, ta + 16); drive(0, OP | 16'h0C30);
    wait_t(20);
    chk(pin_pull == 0 && rise_t == -1, "R1 unused send bits start no pulse", rise_t, -1);
    free_slot(); drive(0, 16'hC004);
    chk(busy[0] == 0, "R1 non-trigger opcode ignored", busy[0], 0);
    clear_all();

    // R5 R7: ch1 waits external, ch0 sends external
    free_slot(); drive(1, OP | 16'h1000);
    wait_t(20);
    free_slot(); ta = tickn; push(0, ta + 16); drive(0, OP | 16'h0040);
    wait_t(20);
    chk(rise_t == ta + 1, "R5 pull starts on first tick", rise_t, ta + 1);
    chk(fall_t - rise_t == 3, "R5 pull width ticks", fall_t - rise_t, 3);
    chk(busy[1] == 1, "R7 own pulse not recognized", busy[1], 1);
    tick_slot(); tt = tickn; push(1, tt + 3); ext_low(tt, 4);
    wait_t(4);
    clear_all();

    // R6 R9: short pulse ignored, disable abandons wait
    free_slot(); drive(2, OP | 16'h1000);
    wait_t(20);
    tick_slot(); tt = tickn; ext_low(tt, 2);
    wait_t(5);
    chk(busy[2] == 1, "R6 one-tick pulse ignored", busy[2], 1);
    @(negedge clk); ch_en[2] = 0; @(negedge clk); ch_en[2] = 1;
    chk(busy[2] == 0, "R9 disable abandons wait", busy[2], 0);

    // R8: self send and wait; external send plus wait
    free_slot(); ta = tickn; push(2, ta + 16); drive(2, OP | 16'h0208);
    wait_t(20);
    free_slot(); drive(0, OP | 16'h1040);
    wait_t(22);
    chk(busy[0] == 1, "R8 R7 external send does not satisfy own wait", busy[0], 1);
    tick_slot(); tt = tickn; push(0, tt + 3); ext_low(tt, 4);
    wait_t(4);
    clear_all();

    // R9: disable clears stored flags
    free_slot(); ta = tickn; push(0, ta + 16); drive(0, OP | 16'h0004);
    wait_t(20);
    @(negedge clk); ch_en[1] = 0; @(negedge clk); ch_en[1] = 1;
    free_slot(); drive(1, OP | 16'h0080);
    wait_t(20);
    chk(busy[1] == 1, "R9 flag cleared by disable", busy[1], 1);
    clear_all();

    // R9: instruction while busy ignored
    free_slot(); ta = tickn; push(0, ta + 16); drive(0, OP | 16'h0004);
    free_slot(); drive(0, OP | 16'h0004);
    wait_t(20);
    free_slot(); ta = tickn; push(1, ta + 16); drive(1, OP | 16'h0080);
    wait_t(20);
    free_slot(); drive(1, OP | 16'h0080);
    wait_t(20);
    chk(busy[1] == 1, "R9 busy instruction not sent", busy[1], 1);

    chk(q0.size() + q1.size() + q2.size() == 0, "R3 all expected completions seen",
        q0.size() + q1.size() + q2.size(), 0);
    if (!fin) begin
      fin = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(5 * 150000);
    if (!fin) begin
      fin = 1;
      chk(0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule